// File: doc/BRIEF.md
# Return Address Stack with Embedded Program Counter

This block keeps a processor's subroutine return addresses in eight on-chip slots of 14 bits each. There is no separate program counter register: the address being executed is whichever slot the level selector currently points at. Sequential execution increments that slot in place. A call steps the selector to the next level and loads the target into the slot it lands on, so the caller's slot keeps its address unchanged. A return steps the selector back, which makes the caller's slot current again.

The level selector does not count in binary. It walks a fixed cyclic order of eight 3-bit codes, and a return walks the same order backwards. A restart strobe carries a small vector number and behaves exactly like a call to a fixed low address; it is the entry path for interrupts. Only return addresses are ever kept, so all eight levels are always available for nesting. Nesting beyond the depth wraps silently: the newest call overwrites the oldest slot, and a return from the outermost level lands on the last level of the order.

Top module: `ret_addr_stack`

## Requirements
- R1: A synchronous active-high reset makes `pc_o` zero one clock later, with the level selector at code 000 and slot 000 cleared to zero.
- R2: With only `step_i` high, `pc_o` becomes its previous value plus one one clock later, wrapping from 0x3FFF to 0x0000. With no strobe high, `pc_o` holds.
- R3: With `call_i` high and `rstr_i` low, `pc_o` equals `call_tgt_i` one clock later.
- R4: A return makes `pc_o`, one clock later, equal to the address the calling level held when the call was taken, including any increments made at that level before the call.
- R5: With `rstr_i` high, `pc_o` becomes `rstr_num_i` placed in bits 5:3 with all other bits zero, one clock later, and the restart is undone by a return like any call.
- R6: Each call or restart moves the level selector one place forward through the cyclic order 000, 001, 010, 101, 011, 111, 110, 100; each return moves it one place back; eight levels nest and unwind in last-in first-out order.
- R7: A call made when all eight levels are in use overwrites the outermost slot without any error indication, and a return from the outermost level wraps to the slot of the last code in the order.
- R8: When several strobes are high in the same cycle, exactly one acts, chosen in the order restart, call, return, step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance the current address by one |
| call_i | input | 1 | Enter a subroutine at `call_tgt_i` |
| call_tgt_i | input | 14 | Subroutine entry address |
| ret_i | input | 1 | Return to the calling level |
| rstr_i | input | 1 | Restart / interrupt entry to a fixed vector |
| rstr_num_i | input | 3 | Restart vector number |
| pc_o | output | 14 | Current program counter (registered) |

## Verification
Directed sequences check the step wrap at the top of the address range, a call followed by a return that must land on an incremented caller address, and restart entry with its vector encoding. Strobe collisions are driven in every combination that matters so that a wrong priority order shows up as a different address. A full eight-deep nest followed by unwinding separates a correct LIFO order from any slot aliasing, and one extra call proves the outermost slot is overwritten and the underflow return wraps. A long seeded random mix of strobes, targets and vectors is then compared against a reference model built on a plain binary depth counter, which would catch any break in the selector's cyclic order.

// File: rtl/ras_pkg.sv
package ras_pkg;

  localparam int LVL_W = 3;
  localparam int DEPTH = 1 << LVL_W;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_STEP = 3'd1,
    OP_CALL = 3'd2,
    OP_VEC  = 3'd3,
    OP_RET  = 3'd4
  } ras_op_e;

  // Forward walk of the level selector (non-binary cycle).
  function automatic logic [LVL_W-1:0] lvl_fwd(input logic [LVL_W-1:0] l);
    logic [LVL_W-1:0] n;
    case (l)
      3'b000:  n = 3'b001;
      3'b001:  n = 3'b010;
      3'b010:  n = 3'b101;
      3'b101:  n = 3'b011;
      3'b011:  n = 3'b111;
      3'b111:  n = 3'b110;
      3'b110:  n = 3'b100;
      default: n = 3'b000;
    endcase
    return n;
  endfunction

  // Backward walk, the inverse of lvl_fwd.
  function automatic logic [LVL_W-1:0] lvl_back(input logic [LVL_W-1:0] l);
    logic [LVL_W-1:0] p;
    case (l)
      3'b001:  p = 3'b000;
      3'b010:  p = 3'b001;
      3'b101:  p = 3'b010;
      3'b011:  p = 3'b101;
      3'b111:  p = 3'b011;
      3'b110:  p = 3'b111;
      3'b100:  p = 3'b110;
      default: p = 3'b100;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ras_op_arb.sv
module ras_op_arb
  import ras_pkg::*;
(
  input  logic    step_i,
  input  logic    call_i,
  input  logic    ret_i,
  input  logic    rstr_i,
  output ras_op_e op_o
);

  always_comb begin
    if (rstr_i)      op_o = OP_VEC;
    else if (call_i) op_o = OP_CALL;
    else if (ret_i)  op_o = OP_RET;
    else if (step_i) op_o = OP_STEP;
    else             op_o = OP_IDLE;
  end

endmodule

// File: rtl/ras_level_ptr.sv
module ras_level_ptr
  import ras_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  ras_op_e          op_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [LVL_W-1:0] lvl_fwd_o,
  output logic [LVL_W-1:0] lvl_back_o
);

  logic [LVL_W-1:0] lvl_q;

  assign lvl_fwd_o  = lvl_fwd(lvl_q);
  assign lvl_back_o = lvl_back(lvl_q);
  assign lvl_o      = lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
    end else begin
      case (op_i)
        OP_CALL, OP_VEC: lvl_q <= lvl_fwd_o;
        OP_RET:          lvl_q <= lvl_back_o;
        default:         lvl_q <= lvl_q;
      endcase
    end
  end

endmodule

// File: rtl/ras_slot_mem.sv
module ras_slot_mem #(
  parameter int WIDTH = 14,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);

  logic [WIDTH-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) slots[waddr_i] <= wdata_i;
  end

  assign rdata_o = slots[raddr_i];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import ras_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int NUM_W     = 3,
  parameter int VEC_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_tgt_i,
  input  logic              ret_i,
  input  logic              rstr_i,
  input  logic [NUM_W-1:0]  rstr_num_i,
  output logic [ADDR_W-1:0] pc_o
);

  ras_op_e          op;
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] lvl_nx;
  logic [LVL_W-1:0] lvl_pv;

  logic              we;
  logic [LVL_W-1:0]  waddr;
  logic [ADDR_W-1:0] wdata;
  logic [ADDR_W-1:0] rdata;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_n;
  logic [ADDR_W-1:0] vec_addr;
  logic [ADDR_W-1:0] pc_inc;

  ras_op_arb u_arb (
    .step_i (step_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .rstr_i (rstr_i),
    .op_o   (op)
  );

  ras_level_ptr u_lvl (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op),
    .lvl_o      (lvl_q),
    .lvl_fwd_o  (lvl_nx),
    .lvl_back_o (lvl_pv)
  );

  ras_slot_mem #(
    .WIDTH (ADDR_W),
    .DEPTH (DEPTH)
  ) u_mem (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (lvl_pv),
    .rdata_o (rdata)
  );

  assign vec_addr = ADDR_W'(rstr_num_i) << VEC_SHIFT;
  assign pc_inc   = pc_q + 1'b1;

  // One write per clock: current slot on step, next slot on call/restart,
  // slot 000 during reset.
  always_comb begin
    we    = 1'b0;
    waddr = lvl_q;
    wdata = pc_inc;
    pc_n  = pc_q;
    case (op)
      OP_STEP: begin
        we    = 1'b1;
        pc_n  = pc_inc;
      end
      OP_CALL: begin
        we    = 1'b1;
        waddr = lvl_nx;
        wdata = call_tgt_i;
        pc_n  = call_tgt_i;
      end
      OP_VEC: begin
        we    = 1'b1;
        waddr = lvl_nx;
        wdata = vec_addr;
        pc_n  = vec_addr;
      end
      OP_RET: begin
        pc_n  = rdata;
      end
      default: ;
    endcase
    if (rst) begin
      we    = 1'b1;
      waddr = '0;
      wdata = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_n;
  end

  assign pc_o = pc_q;

endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int ADDR_W    = 14,
  parameter int NUM_W     = 3,
  parameter int VEC_SHIFT = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              step_i,
  input logic              call_i,
  input logic [ADDR_W-1:0] call_tgt_i,
  input logic              ret_i,
  input logic              rstr_i,
  input logic [NUM_W-1:0]  rstr_num_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic [2:0]        lvl_q
);

  localparam logic [2:0] ORD [8] = '{3'd0, 3'd1, 3'd2, 3'd5, 3'd3, 3'd7, 3'd6, 3'd4};

  function automatic logic [2:0] ord_pos(input logic [2:0] code);
    logic [2:0] p;
    p = '0;
    for (int k = 0; k < 8; k++) if (ORD[k] == code) p = 3'(k);
    return p;
  endfunction

  function automatic logic [2:0] ord_after(input logic [2:0] code);
    return ORD[ord_pos(code) + 3'd1];
  endfunction

  function automatic logic [2:0] ord_before(input logic [2:0] code);
    return ORD[ord_pos(code) - 3'd1];
  endfunction

  logic [1:0] live_cnt;
  always_ff @(posedge clk) begin
    if (rst)                 live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  logic only_step, only_ret, no_strobe;
  assign only_step = step_i && !call_i && !ret_i && !rstr_i;
  assign only_ret  = ret_i && !call_i && !rstr_i;
  assign no_strobe = !step_i && !call_i && !ret_i && !rstr_i;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && lvl_q == 3'b000));

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    only_step |=> pc_o == ADDR_W'($past(pc_o) + 1'b1));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    no_strobe |=> $stable(pc_o));

  // R3
  call_load_chk: assert property (@(posedge clk) disable iff (rst)
    (call_i && !rstr_i) |=> pc_o == $past(call_tgt_i));

  // R5
  restart_vec_chk: assert property (@(posedge clk) disable iff (rst)
    rstr_i |=> pc_o == (ADDR_W'($past(rstr_num_i)) << VEC_SHIFT));

  // R4
  call_ret_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (live_cnt != 2'd0 && $past(call_i && !rstr_i) && only_ret) |=> pc_o == $past(pc_o, 2));

  // R6
  level_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (call_i || rstr_i) |=> lvl_q == ord_after($past(lvl_q)));

  // R6
  level_back_chk: assert property (@(posedge clk) disable iff (rst)
    only_ret |=> lvl_q == ord_before($past(lvl_q)));

  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!call_i && !rstr_i && !ret_i) |=> $stable(lvl_q));

endmodule

bind ret_addr_stack ret_addr_stack_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_W     (NUM_W),
  .VEC_SHIFT (VEC_SHIFT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step_i     (step_i),
  .call_i     (call_i),
  .call_tgt_i (call_tgt_i),
  .ret_i      (ret_i),
  .rstr_i     (rstr_i),
  .rstr_num_i (rstr_num_i),
  .pc_o       (pc_o),
  .lvl_q      (lvl_q)
);

// File: tb/ret_addr_stack_test.sv
module ret_addr_stack_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 14;
  localparam int NW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          step_i = 1'b0;
  logic          call_i = 1'b0;
  logic [AW-1:0] call_tgt_i = '0;
  logic          ret_i = 1'b0;
  logic          rstr_i = 1'b0;
  logic [NW-1:0] rstr_num_i = '0;
  logic [AW-1:0] pc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Reference: binary depth index into an eight-slot array.
  logic [AW-1:0] mdl [8];
  bit            mvalid [8];
  logic [2:0]    dp;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_addr_stack uut (
    .clk        (clk),
    .rst        (rst),
    .step_i     (step_i),
    .call_i     (call_i),
    .call_tgt_i (call_tgt_i),
    .ret_i      (ret_i),
    .rstr_i     (rstr_i),
    .rstr_num_i (rstr_num_i),
    .pc_o       (pc_o)
  );

  task automatic check(input string tag, input logic [AW-1:0] exp);
    n_chk++;
    if (pc_o !== exp) begin
      n_bad++;
      $display("FAIL %s: pc_o actual %h expected %h", tag, pc_o, exp);
    end
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    step_i = 0; call_i = 0; ret_i = 0; rstr_i = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    dp = 3'd0;
    for (int k = 0; k < 8; k++) mvalid[k] = 1'b0;
    mdl[0] = '0;
    mvalid[0] = 1'b1;
    check(tag, '0);
  endtask

  task automatic step(input logic a, input logic c, input logic r, input logic s,
                      input logic [AW-1:0] t, input logic [NW-1:0] n, input string tag);
    step_i = a; call_i = c; ret_i = r; rstr_i = s;
    call_tgt_i = t; rstr_num_i = n;
    if (s) begin
      dp = dp + 3'd1;
      mdl[dp] = AW'(n) << 3;
      mvalid[dp] = 1'b1;
    end else if (c) begin
      dp = dp + 3'd1;
      mdl[dp] = t;
      mvalid[dp] = 1'b1;
    end else if (r) begin
      dp = dp - 3'd1;
    end else if (a) begin
      mdl[dp] = mdl[dp] + 1'b1;
    end
    @(negedge clk);
    step_i = 0; call_i = 0; ret_i = 0; rstr_i = 0;
    check(tag, mdl[dp]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240613);
    @(negedge clk);
    do_reset("R1 reset");

    step(1,0,0,0,'0,'0,"R2 step");
    step(1,0,0,0,'0,'0,"R2 step");
    step(1,0,0,0,'0,'0,"R2 step");
    step(0,0,0,0,'0,'0,"R2 idle hold");
    step(0,1,0,0,14'h3FFE,'0,"R3 call");
    step(1,0,0,0,'0,'0,"R2 step");
    step(1,0,0,0,'0,'0,"R2 wrap to zero");
    step(0,0,1,0,'0,'0,"R4 return to caller");

    step(0,0,0,1,'0,3'd5,"R5 restart vector 5");
    step(1,0,0,0,'0,'0,"R2 step in handler");
    step(0,0,1,0,'0,'0,"R5 return from restart");
    step(0,0,0,1,'0,3'd7,"R5 restart vector 7");
    step(0,0,1,0,'0,'0,"R5 return from restart");

    step(1,1,1,1,14'h0123,3'd2,"R8 restart wins all");
    step(1,1,1,0,14'h0200,'0,"R8 call beats return and step");
    step(1,0,1,0,'0,'0,"R8 return beats step");
    step(0,0,1,0,'0,'0,"R4 return");

    for (int k = 0; k < 7; k++)
      step(0,1,0,0,AW'(14'h0100 + k),'0,"R6 nest");
    for (int k = 0; k < 7; k++)
      step(0,0,1,0,'0,'0,"R6 unwind");

    step(1,0,0,0,'0,'0,"R2 step");
    for (int k = 0; k < 8; k++)
      step(0,1,0,0,AW'(14'h0A00 + k),'0,"R7 overfill");
    for (int k = 0; k < 7; k++)
      step(0,0,1,0,'0,'0,"R7 unwind");
    step(0,0,1,0,'0,'0,"R7 outermost overwritten");
    step(0,0,1,0,'0,'0,"R7 underflow wrap");

    do_reset("R1 mid-run reset");
    step(1,0,0,0,'0,'0,"R1 post-reset step");

    for (int i = 0; i < 3000; i++) begin
      logic a, c, r, s;
      a = ($urandom % 2) == 0;
      c = ($urandom % 5) == 0;
      r = ($urandom % 4) == 0;
      s = ($urandom % 12) == 0;
      if (!s && !c && r && !mvalid[dp - 3'd1]) r = 1'b0;
      step(a, c, r, s, AW'($urandom), NW'($urandom), "R3 random mix");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule